// File: doc/BRIEF.md
# Pipelined Best-State Search

This block sits beside a folded path-metric engine that produces eight path metrics per clock, each tagged with the trellis state it belongs to. It finds the state with the lowest path metric over a whole trellis iteration. That state is then used as the starting point of a survivor-path walk.

Each accepted beat of eight metric/state pairs is reduced to a single winner by a balanced, registered compare-select tree. The tree has seven nodes arranged in three levels. The tree's winners are then folded into a running best that restarts at the first beat of every iteration.

The number of beats in one iteration follows the configured constraint length. It is 8, 16, 32 or 64 beats. When the last beat of an iteration has been folded in, the block raises a one-cycle strobe with the winning state index. Beats marked not-valid are skipped entirely.

Top module: `best_state_finder`

## Requirements
- R1: While and directly after synchronous active-low reset, `best_valid` is 0 and `best_state` is 0.
- R2: The reported state is the one whose metric is smallest over all beats of the iteration, with metrics compared as unsigned numbers.
- R3: When several candidates share the smallest metric, within one beat or across beats, the one with the numerically lowest state index is reported.
- R4: `cfg_len` encodes the iteration length in valid beats: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. It must be held steady during an iteration.
- R5: `best_valid` is high in the cycle that follows the fourth rising edge, counting the edge that samples the last valid beat of the iteration as the first.
- R6: `best_valid` is high for exactly one cycle per completed iteration and never at any other time.
- R7: `best_state` keeps its value in every cycle in which `best_valid` is low.
- R8: A cycle with `in_valid` low neither advances the beat count nor takes part in the search, whatever metrics it carries.
- R9: The search restarts at the first beat of each iteration, so metrics of earlier iterations have no effect on the result.
- R10: Lane j takes its metric from `in_metric[6j+5:6j]` and its state from `in_state[9j+8:9j]`, and all 9 state bits are carried to `best_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len | input | 2 | Iteration length select (constraint length 7..10) |
| in_valid | input | 1 | Beat of eight metric/state pairs present |
| in_metric | input | 48 | Eight 6-bit unsigned path metrics, lane 0 in the low bits |
| in_state | input | 72 | Eight 9-bit state indices, lane 0 in the low bits |
| best_valid | output | 1 | One-cycle strobe marking the end-of-iteration result |
| best_state | output | 9 | State index with the best metric of the last iteration |

## Verification
The hardest situation to reach is a tie on the minimum metric across beats of one iteration. This is made harder when it is combined with not-valid cycles that carry an even better metric, which would win if the beat counter or the fold wrongly accepted them. The bench drives an equal-metric pattern whose lowest state index sits in a middle beat, and a gap pattern whose idle cycles carry metric 0. It also runs iterations back to back, so the strobe of one iteration appears while the next is already streaming in. A pattern of uniformly large metrics follows one that contained a zero, which exposes any carry-over of the running best from one iteration to the next.

// File: rtl/bss_pkg.sv
// Shared constants and types of the best-state search block.
// Assumes metrics are unsigned, smaller is better.
package bss_pkg;
    localparam int unsigned PM_W     = 6;   // path metric width
    localparam int unsigned ST_W     = 9;   // state index width (512 states)
    localparam int unsigned LANES    = 8;   // metrics per clock
    localparam int unsigned BASE_CYC = 8;   // beats per iteration at the shortest code

    // Iteration length select, one code per constraint length.
    typedef enum logic [1:0] {
        CL7  = 2'd0,
        CL8  = 2'd1,
        CL9  = 2'd2,
        CL10 = 2'd3
    } cl_sel_e;
endpackage

// File: rtl/bss_cmp.sv
// Combinational compare-select: passes the smaller metric with its state.
// On equal metrics the lower state index wins, which makes the result
// independent of lane and beat order.
module bss_cmp #(
    parameter int unsigned MW = 6,
    parameter int unsigned SW = 9
) (
    input  logic [MW-1:0] a_m,
    input  logic [SW-1:0] a_s,
    input  logic [MW-1:0] b_m,
    input  logic [SW-1:0] b_s,
    output logic [MW-1:0] w_m,
    output logic [SW-1:0] w_s
);
    logic take_a;

    // Choose side a on a strictly smaller metric or on a tie with lower index.
    always_comb begin
        take_a = (a_m < b_m) || ((a_m == b_m) && (a_s <= b_s));
        w_m    = take_a ? a_m : b_m;
        w_s    = take_a ? a_s : b_s;
    end
endmodule

// File: rtl/bss_node.sv
// One registered tree node: a compare-select followed by a pipeline register.
// Assumes a synchronous active-low reset; the node runs every cycle.
module bss_node #(
    parameter int unsigned MW = 6,
    parameter int unsigned SW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] a_m,
    input  logic [SW-1:0] a_s,
    input  logic [MW-1:0] b_m,
    input  logic [SW-1:0] b_s,
    output logic [MW-1:0] q_m,
    output logic [SW-1:0] q_s
);
    logic [MW-1:0] c_m;
    logic [SW-1:0] c_s;

    bss_cmp #(.MW(MW), .SW(SW)) u_cmp (
        .a_m(a_m), .a_s(a_s), .b_m(b_m), .b_s(b_s),
        .w_m(c_m), .w_s(c_s)
    );

    // Register the local winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_m <= '0;
            q_s <= '0;
        end else begin
            q_m <= c_m;
            q_s <= c_s;
        end
    end
endmodule

// File: rtl/bss_tree.sv
// Balanced registered reduction tree laid out as a heap: node i has
// children 2i+1 and 2i+2, and the leaves LANES-1 .. 2*LANES-2 are the
// input lanes. The latency is log2(LANES) cycles. Beat tags (valid,
// first, last) travel alongside the data. Assumes LANES is a power of two
// and at least 2.
module bss_tree #(
    parameter int unsigned LANES = 8,
    parameter int unsigned MW    = 6,
    parameter int unsigned SW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic                in_last,
    input  logic [LANES*MW-1:0] in_metric,
    input  logic [LANES*SW-1:0] in_state,
    output logic                out_valid,
    output logic                out_first,
    output logic                out_last,
    output logic [MW-1:0]       out_m,
    output logic [SW-1:0]       out_s
);
    localparam int unsigned LVL   = $clog2(LANES);
    localparam int unsigned NODES = 2 * LANES - 1;

    logic [NODES*MW-1:0] nm;
    logic [NODES*SW-1:0] ns;
    logic [LVL-1:0]      v_pipe;
    logic [LVL-1:0]      f_pipe;
    logic [LVL-1:0]      l_pipe;

    for (genvar j = 0; j < LANES; j++) begin : g_leaf
        assign nm[(LANES-1+j)*MW +: MW] = in_metric[j*MW +: MW];
        assign ns[(LANES-1+j)*SW +: SW] = in_state[j*SW +: SW];
    end

    for (genvar i = 0; i < LANES - 1; i++) begin : g_node
        bss_node #(.MW(MW), .SW(SW)) u_node (
            .clk(clk), .rst_n(rst_n),
            .a_m(nm[(2*i+1)*MW +: MW]), .a_s(ns[(2*i+1)*SW +: SW]),
            .b_m(nm[(2*i+2)*MW +: MW]), .b_s(ns[(2*i+2)*SW +: SW]),
            .q_m(nm[i*MW +: MW]),       .q_s(ns[i*SW +: SW])
        );
    end

    // Delay the beat tags by the depth of the tree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_pipe <= '0;
            f_pipe <= '0;
            l_pipe <= '0;
        end else begin
            v_pipe[0] <= in_valid;
            f_pipe[0] <= in_first;
            l_pipe[0] <= in_last;
            for (int k = 1; k < LVL; k++) begin
                v_pipe[k] <= v_pipe[k-1];
                f_pipe[k] <= f_pipe[k-1];
                l_pipe[k] <= l_pipe[k-1];
            end
        end
    end

    assign out_valid = v_pipe[LVL-1];
    assign out_first = f_pipe[LVL-1];
    assign out_last  = l_pipe[LVL-1];
    assign out_m     = nm[MW-1:0];
    assign out_s     = ns[SW-1:0];
endmodule

// File: rtl/bss_fold.sv
// Folds per-beat tree winners into a running best over one iteration.
// The first beat replaces the running best; the last beat publishes the
// result with a one-cycle strobe. Beats that are not valid are ignored.
module bss_fold #(
    parameter int unsigned MW = 6,
    parameter int unsigned SW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t_valid,
    input  logic          t_first,
    input  logic          t_last,
    input  logic [MW-1:0] t_m,
    input  logic [SW-1:0] t_s,
    output logic          best_valid,
    output logic [SW-1:0] best_state
);
    logic [MW-1:0] acc_m;
    logic [SW-1:0] acc_s;
    logic [MW-1:0] mg_m;
    logic [SW-1:0] mg_s;
    logic [MW-1:0] cand_m;
    logic [SW-1:0] cand_s;

    bss_cmp #(.MW(MW), .SW(SW)) u_cmp (
        .a_m(acc_m), .a_s(acc_s), .b_m(t_m), .b_s(t_s),
        .w_m(mg_m),  .w_s(mg_s)
    );

    // Restart on the first beat, else merge with the running best.
    always_comb begin
        cand_m = t_first ? t_m : mg_m;
        cand_s = t_first ? t_s : mg_s;
    end

    // Hold the running best and publish it at the end of the iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_m      <= '0;
            acc_s      <= '0;
            best_valid <= 1'b0;
            best_state <= '0;
        end else begin
            best_valid <= t_valid && t_last;
            if (t_valid) begin
                acc_m <= cand_m;
                acc_s <= cand_s;
                if (t_last) begin
                    best_state <= cand_s;
                end
            end
        end
    end
endmodule

// File: rtl/best_state_finder.sv
// Top of the best-state search. It counts valid beats within an iteration
// whose length is set by cfg_len, tags the first and last beat, reduces
// each beat in a registered tree and folds the winners. Assumes cfg_len is
// steady for the whole of an iteration.
module best_state_finder
    import bss_pkg::*;
#(
    parameter int unsigned MW   = PM_W,
    parameter int unsigned SW   = ST_W,
    parameter int unsigned NL   = LANES,
    parameter int unsigned BASE = BASE_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_len,
    input  logic             in_valid,
    input  logic [NL*MW-1:0] in_metric,
    input  logic [NL*SW-1:0] in_state,
    output logic             best_valid,
    output logic [SW-1:0]    best_state
);
    localparam int unsigned MAXB = BASE * 8;
    localparam int unsigned CW   = $clog2(MAXB);

    cl_sel_e       cl;
    logic [CW:0]   span;
    logic [CW-1:0] cnt;
    logic          beat_first;
    logic          beat_last;
    logic          t_valid;
    logic          t_first;
    logic          t_last;
    logic [MW-1:0] t_m;
    logic [SW-1:0] t_s;

    assign cl = cl_sel_e'(cfg_len);

    // Beats per iteration for the selected constraint length.
    always_comb begin
        case (cl)
            CL7:     span = (CW+1)'(BASE);
            CL8:     span = (CW+1)'(BASE * 2);
            CL9:     span = (CW+1)'(BASE * 4);
            default: span = (CW+1)'(BASE * 8);
        endcase
    end

    assign beat_first = (cnt == '0);
    assign beat_last  = ({1'b0, cnt} >= (span - (CW+1)'(1)));

    // Count valid beats within the current iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (in_valid) begin
            cnt <= beat_last ? '0 : cnt + CW'(1);
        end
    end

    bss_tree #(.LANES(NL), .MW(MW), .SW(SW)) u_tree (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_first(beat_first), .in_last(beat_last),
        .in_metric(in_metric), .in_state(in_state),
        .out_valid(t_valid), .out_first(t_first), .out_last(t_last),
        .out_m(t_m), .out_s(t_s)
    );

    bss_fold #(.MW(MW), .SW(SW)) u_fold (
        .clk(clk), .rst_n(rst_n),
        .t_valid(t_valid), .t_first(t_first), .t_last(t_last),
        .t_m(t_m), .t_s(t_s),
        .best_valid(best_valid), .best_state(best_state)
    );
endmodule

// File: rtl/bss_chk.sv
// Temporal checks on the ports of best_state_finder, attached by bind.
module bss_chk #(
    parameter int unsigned SW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          best_valid,
    input logic [SW-1:0] best_state
);
    // R1: reset leaves the strobe low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !best_valid);

    // R6: the strobe lasts a single cycle.
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |=> !best_valid);

    // R5: a strobe is preceded four edges earlier by an accepted beat.
    p_strobe_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> $past(in_valid, 4));

    // R7: the result holds while no strobe is shown.
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid |-> $stable(best_state));
endmodule

bind best_state_finder bss_chk #(.SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .best_valid(best_valid), .best_state(best_state)
);

// File: tb/sim_best_state_finder.sv
`timescale 1ns/1ps
module sim_best_state_finder;
    localparam int MW = 6;
    localparam int SW = 9;
    localparam int NL = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_len = 2'd0;
    logic             in_valid = 1'b0;
    logic [NL*MW-1:0] in_metric = '0;
    logic [NL*SW-1:0] in_state = '0;
    logic             best_valid;
    logic [SW-1:0]    best_state;

    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [SW-1:0] held = '0;
    int    exp_e[$];
    int    exp_s[$];
    string exp_t[$];

    best_state_finder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .in_valid(in_valid),
        .in_metric(in_metric), .in_state(in_state),
        .best_valid(best_valid), .best_state(best_state)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    // Compare strobes and held results against the expected schedule.
    always @(negedge clk) begin
        if (mon_on) begin
            if (best_valid) begin
                checks++;
                if (exp_e.size() == 0 || exp_e[0] != edge_cnt) begin
                    errors++;
                    $display("FAIL R6 strobe at edge %0d state %0h, expected no strobe", edge_cnt, best_state);
                end else begin
                    checks++;
                    if (best_state !== SW'(exp_s[0])) begin
                        errors++;
                        $display("FAIL %s state %0h expected %0h", exp_t[0], best_state, exp_s[0]);
                    end
                    void'(exp_e.pop_front());
                    void'(exp_s.pop_front());
                    void'(exp_t.pop_front());
                end
                held = best_state;
            end else begin
                if (exp_e.size() > 0 && exp_e[0] == edge_cnt) begin
                    checks++;
                    errors++;
                    $display("FAIL R4 R5 no strobe at edge %0d, expected strobe with %0h", edge_cnt, exp_s[0]);
                    void'(exp_e.pop_front());
                    void'(exp_s.pop_front());
                    void'(exp_t.pop_front());
                end
                checks++;
                if (best_state !== held) begin
                    errors++;
                    $display("FAIL R7 state %0h expected held %0h", best_state, held);
                end
            end
        end
    end

    // Per-lane stimulus; expected values are derived from the same numbers.
    function automatic int gen_m(int pat, int seed, int b, int l, int n);
        case (pat)
            0: return (seed * 29 + b * 13 + l * 7 + b * l * 5) % 61 + 2;
            1: return 20;
            2: return (b == seed % n && l == seed % 8) ? 0 : 40 + (l + b) % 20;
            3: return 10 + (b + l + seed) % 50;
            default: return (b == n - 1 && l == 7) ? 62 : 63;
        endcase
    endfunction

    function automatic int gen_s(int pat, int seed, int b, int l, int n);
        case (pat)
            0: return (seed * 97 + b * 8 + l * 41 + b * l) % 512;
            1: return 100 + (b * 37 + l * 71 + seed) % 400;
            2: return (b == seed % n && l == seed % 8) ? 9'h1A5 : (b * 8 + l) ^ seed;
            3: return (b * 53 + l * 19 + seed) % 512;
            default: return 511 - (b * 8 + l) % 256;
        endcase
    endfunction

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b0;
            in_metric = '0;
            in_state = {NL{9'd1}};
            @(negedge clk);
        end
    endtask

    // Drive one iteration; gap cycles carry metric 0, which must be ignored (R8).
    task automatic run_iter(int cfg, int pat, int seed, bit gaps, string tag);
        int n;
        int bm;
        int bs;
        n = 8 << cfg;
        bm = 1000;
        bs = 0;
        cfg_len = 2'(cfg);
        for (int b = 0; b < n; b++) begin
            if (gaps && (b % 3 == 1)) idle(1 + b % 2);
            in_valid = 1'b1;
            for (int l = 0; l < NL; l++) begin
                int m;
                int s;
                m = gen_m(pat, seed, b, l, n);
                s = gen_s(pat, seed, b, l, n);
                in_metric[l*MW +: MW] = MW'(m);
                in_state[l*SW +: SW] = SW'(s);
                if (m < bm || (m == bm && s < bs)) begin
                    bm = m;
                    bs = s;
                end
            end
            if (b == n - 1) begin
                exp_e.push_back(edge_cnt + 4);
                exp_s.push_back(bs);
                exp_t.push_back(tag);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (best_valid !== 1'b0 || best_state !== '0) begin
            errors++;
            $display("FAIL R1 valid %0b state %0h expected 0 0", best_valid, best_state);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (best_valid !== 1'b0 || best_state !== '0) begin
            errors++;
            $display("FAIL R1 after release valid %0b state %0h expected 0 0", best_valid, best_state);
        end
        mon_on = 1'b1;
        for (int c = 0; c < 4; c++) begin
            // back-to-back iterations: R2, R3, R10, R9 and R4 per length
            run_iter(c, 0, c + 1, 1'b0, "R2 R4 varied metrics");
            run_iter(c, 1, c + 3, 1'b0, "R3 equal metrics");
            run_iter(c, 2, c * 11 + 5, 1'b0, "R2 R10 single zero");
            run_iter(c, 3, c + 7, 1'b0, "R9 restart after zero");
            run_iter(c, 0, c + 9, 1'b1, "R8 idle slots");
            idle(6);
            run_iter(c, 4, 0, 1'b0, "R2 R3 winner in last beat");
            idle(3);
        end
        idle(8);
        checks++;
        if (exp_e.size() != 0) begin
            errors++;
            $display("FAIL R6 pending strobes %0d expected 0", exp_e.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog expired, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule